// File: doc/BRIEF.md
# Serial EEPROM Device-Address Decoder

This block sits behind a two-wire bus front end. The front end detects START and STOP conditions and delivers each received byte as a single-cycle strobe. The block reads the first byte after every START, including a repeated START, as a device address. The upper nibble must carry the fixed memory-device type code. Some of the next three bits are compared against strapped chip-select pins. The remaining bits of that group are memory page bits. The lowest bit gives the transfer direction.

A density parameter decides how that three-bit group is split. At 4 Kbit, the two upper bits are chip selects and the lowest bit is a page bit. At 8 Kbit, only the upper bit is a chip select and the other two are page bits. A small-package parameter forces every compared chip-select value to zero.

On a match, the block requests an acknowledge for the ninth clock. It then latches the page bits and the direction, and passes each later byte on as data. On a mismatch, it goes to standby and ignores the bus until the next START.

Top module: `devaddr_decoder`

## Requirements
- R1: After reset, addr_match, ack_req, page_sel, dir_read, data_strobe and data_byte are all zero.
- R2: A byte whose bits 7:4 differ from 4'b1010 is never matched: no ack_req, and addr_match stays 0.
- R3: With DENSITY_KB=4, byte bit 3 is compared with strap_pins[2] and bit 2 with strap_pins[1]. Byte bit 1 becomes page_sel[0], page_sel[1] reads 0, and strap_pins[0] has no effect.
- R4: With DENSITY_KB=8, only byte bit 3 is compared with strap_pins[2]. Byte bits 2:1 become page_sel[1:0], and strap_pins[1:0] have no effect.
- R5: On a match, dir_read equals byte bit 0 (1 = read, 0 = write). While the block is not matched, dir_read and page_sel read 0.
- R6: The cycle after a matching address byte is strobed, ack_req is high for exactly one cycle and addr_match rises. addr_match then holds until a STOP or START.
- R7: After a mismatching address byte, the block is in standby. Further bytes give no ack_req and no data_strobe until the next START.
- R8: With SMALL_PKG=1, the compared chip-select values are 0 whatever the level of strap_pins.
- R9: Only the first byte after a START is decoded as an address. While matched, each later byte gives a one-cycle data_strobe with data_byte equal to that byte, no ack_req, and no change to page_sel or dir_read.
- R10: A STOP clears addr_match, page_sel and dir_read in the next cycle. A byte strobed in the same cycle as a STOP is discarded.
- R11: A START, including a repeated START while matched, clears addr_match. The next byte is then decoded afresh. A byte strobed in the same cycle as a START is discarded.
- R12: Bytes strobed before any START after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_seen | input | 1 | One-cycle pulse on START or repeated START |
| stop_seen | input | 1 | One-cycle pulse on STOP |
| byte_valid | input | 1 | One-cycle strobe: byte_in holds a complete received byte |
| byte_in | input | 8 | Received byte, MSB first on the wire |
| strap_pins | input | 3 | Strapped chip-select pins {A2, A1, A0} |
| addr_match | output | 1 | Device selected since the last address byte |
| ack_req | output | 1 | One-cycle request to drive SDA low in the ninth clock |
| page_sel | output | 2 | Latched memory page bits |
| dir_read | output | 1 | Latched direction, 1 = read |
| data_strobe | output | 1 | One-cycle strobe: data_byte holds a byte for the selected device |
| data_byte | output | 8 | Last byte passed on as data |

## Verification
A byte strobe can arrive in the same cycle as a START or STOP pulse. Here, bus control must win over byte handling.

The bench provokes this in two ways. It strobes a data byte together with a STOP while matched; there it expects no data_strobe, and addr_match, page_sel and dir_read cleared in the next cycle. It also strobes a matching address byte together with a START; there it expects no ack_req, and then expects the following byte to be decoded as the address.

All density and package variants are swept over every strap setting and every address byte. The expected match, page bits and direction are computed arithmetically from the byte's field positions.

// File: rtl/devaddr_pkg.sv
package devaddr_pkg;

  // Fixed memory-device type code carried in the address byte's upper nibble.
  localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;

  typedef enum logic [1:0] {
    ST_STANDBY  = 2'd0,
    ST_ADDR     = 2'd1,
    ST_SELECTED = 2'd2
  } dev_state_t;

  // Page bits taken from the three-bit select group for a given density.
  function automatic int page_bit_count(input int density_kb);
    return (density_kb >= 8) ? 2 : 1;
  endfunction

  // Mask over byte bits [3:1]: index 2 is byte bit 3. A set bit is compared
  // against its strap pin; a clear bit is a page bit.
  function automatic logic [2:0] cs_compare_mask(input int pg_bits);
    logic [2:0] m;
    m = '0;
    for (int i = 0; i < 3; i++) begin
      if (i >= pg_bits) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic cs_agree(input logic [7:0] b, input logic [2:0] pins,
                                    input logic [2:0] mask);
    return ((b[3:1] ^ pins) & mask) == 3'b000;
  endfunction

  function automatic logic [1:0] page_field(input logic [7:0] b, input logic [2:0] mask);
    logic [2:0] f;
    f = b[3:1] & ~mask;
    return f[1:0];
  endfunction

endpackage

// File: rtl/devaddr_field_split.sv
module devaddr_field_split
  import devaddr_pkg::*;
#(
  parameter int DENSITY_KB = 4,
  parameter bit SMALL_PKG  = 1'b0
) (
  input  logic [7:0] addr_byte,
  input  logic [2:0] strap_pins,
  output logic       prefix_ok,
  output logic       cs_ok,
  output logic [1:0] page_sel,
  output logic       rd_sel
);

  localparam int         PG_BITS = page_bit_count(DENSITY_KB);
  localparam logic [2:0] CS_MASK = cs_compare_mask(PG_BITS);

  logic [2:0] pins_eff;

  generate
    if (SMALL_PKG) begin : g_tied
      assign pins_eff = 3'b000;
    end else begin : g_strapped
      assign pins_eff = strap_pins;
    end
  endgenerate

  assign prefix_ok = (addr_byte[7:4] == DEV_TYPE_CODE);
  assign cs_ok     = cs_agree(addr_byte, pins_eff, CS_MASK);
  assign page_sel  = page_field(addr_byte, CS_MASK);
  assign rd_sel    = addr_byte[0];

endmodule

// File: rtl/devaddr_select_fsm.sv
module devaddr_select_fsm
  import devaddr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_seen,
  input  logic stop_seen,
  input  logic byte_valid,
  input  logic addr_hit,
  output logic addr_eval,
  output logic data_eval
);

  dev_state_t state_q, state_d;
  logic       bus_ctl;

  assign bus_ctl   = start_seen | stop_seen;
  assign addr_eval = byte_valid && !bus_ctl && (state_q == ST_ADDR);
  assign data_eval = byte_valid && !bus_ctl && (state_q == ST_SELECTED);

  always_comb begin
    state_d = state_q;
    if (start_seen)     state_d = ST_ADDR;
    else if (stop_seen) state_d = ST_STANDBY;
    else if (addr_eval) state_d = addr_hit ? ST_SELECTED : ST_STANDBY;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_STANDBY;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/devaddr_decoder.sv
module devaddr_decoder
  import devaddr_pkg::*;
#(
  parameter int DENSITY_KB = 4,
  parameter bit SMALL_PKG  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_seen,
  input  logic       stop_seen,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic [2:0] strap_pins,
  output logic       addr_match,
  output logic       ack_req,
  output logic [1:0] page_sel,
  output logic       dir_read,
  output logic       data_strobe,
  output logic [7:0] data_byte
);

  logic       prefix_ok, cs_ok, rd_sel;
  logic [1:0] page_dec;
  logic       addr_hit;   // decoded byte would select this device
  logic       addr_eval;  // this cycle's byte is decoded as an address
  logic       data_eval;  // this cycle's byte is passed on as data

  devaddr_field_split #(
    .DENSITY_KB(DENSITY_KB),
    .SMALL_PKG (SMALL_PKG)
  ) u_split (
    .addr_byte (byte_in),
    .strap_pins(strap_pins),
    .prefix_ok (prefix_ok),
    .cs_ok     (cs_ok),
    .page_sel  (page_dec),
    .rd_sel    (rd_sel)
  );

  assign addr_hit = prefix_ok & cs_ok;

  devaddr_select_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_seen(start_seen),
    .stop_seen (stop_seen),
    .byte_valid(byte_valid),
    .addr_hit  (addr_hit),
    .addr_eval (addr_eval),
    .data_eval (data_eval)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_match  <= 1'b0;
      ack_req     <= 1'b0;
      page_sel    <= 2'b00;
      dir_read    <= 1'b0;
      data_strobe <= 1'b0;
      data_byte   <= 8'h00;
    end else begin
      ack_req     <= addr_eval & addr_hit;
      data_strobe <= data_eval;
      if (data_eval) data_byte <= byte_in;
      if (start_seen || stop_seen) begin
        addr_match <= 1'b0;
        page_sel   <= 2'b00;
        dir_read   <= 1'b0;
      end else if (addr_eval) begin
        addr_match <= addr_hit;
        page_sel   <= addr_hit ? page_dec : 2'b00;
        dir_read   <= addr_hit & rd_sel;
      end
    end
  end

endmodule

module devaddr_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_seen,
  input logic       stop_seen,
  input logic       byte_valid,
  input logic [7:0] byte_in,
  input logic       addr_eval,
  input logic       addr_hit,
  input logic       addr_match,
  input logic       ack_req,
  input logic [1:0] page_sel,
  input logic       dir_read,
  input logic       data_strobe
);

  AST_ACK_WITH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> addr_match); // R6
  AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req); // R6
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(byte_valid)); // R6
  AST_HIT_GIVES_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eval && addr_hit) |=> ack_req); // R6
  AST_TYPE_CODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> ($past(byte_in[7:4]) == 4'b1010)); // R2
  AST_DIR_FROM_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> (dir_read == $past(byte_in[0]))); // R5
  AST_MISS_STAYS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_eval && !addr_hit) |=> (!addr_match && !ack_req)); // R7
  AST_DATA_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    data_strobe |-> (addr_match && !ack_req)); // R9
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_seen |=> (!addr_match && page_sel == 2'b00 && !dir_read && !data_strobe)); // R10
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (!addr_match && !ack_req && !data_strobe)); // R11

endmodule

bind devaddr_decoder devaddr_decoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_seen (start_seen),
  .stop_seen  (stop_seen),
  .byte_valid (byte_valid),
  .byte_in    (byte_in),
  .addr_eval  (addr_eval),
  .addr_hit   (addr_hit),
  .addr_match (addr_match),
  .ack_req    (ack_req),
  .page_sel   (page_sel),
  .dir_read   (dir_read),
  .data_strobe(data_strobe)
);

// File: tb/devaddr_decoder_test.sv
`timescale 1ns/1ps
module devaddr_decoder_test;

  localparam int NCFG = 4;
  localparam int CFG_KB [NCFG] = '{4, 8, 4, 8};
  localparam int CFG_SP [NCFG] = '{0, 0, 1, 1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_seen = 1'b0, stop_seen = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [2:0] strap_pins = 3'b000;

  logic       am [NCFG];
  logic       ak [NCFG];
  logic [1:0] pg [NCFG];
  logic       rd [NCFG];
  logic       ds [NCFG];
  logic [7:0] db [NCFG];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    devaddr_decoder #(.DENSITY_KB(CFG_KB[g]), .SMALL_PKG(CFG_SP[g] != 0)) uut (
      .clk(clk), .rst_n(rst_n), .start_seen(start_seen), .stop_seen(stop_seen),
      .byte_valid(byte_valid), .byte_in(byte_in), .strap_pins(strap_pins),
      .addr_match(am[g]), .ack_req(ak[g]), .page_sel(pg[g]), .dir_read(rd[g]),
      .data_strobe(ds[g]), .data_byte(db[g]));
  end

  task automatic check(input string req, input int cfg, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cfg%0d: actual %0d expected %0d", req, cfg, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; return at the next falling edge.
  task automatic cycle(input bit st, input bit sp, input bit bv, input int b);
    start_seen = st; stop_seen = sp; byte_valid = bv; byte_in = b[7:0];
    @(negedge clk);
    start_seen = 1'b0; stop_seen = 1'b0; byte_valid = 1'b0;
  endtask

  // Independent model of the address decode.
  task automatic model(input int kb, input int sp, input int b, input int pins,
                       output int hit, output int page, output int dir);
    int a2, a1;
    a2 = sp ? 0 : (pins >> 2) & 1;
    a1 = sp ? 0 : (pins >> 1) & 1;
    hit = ((b / 16) == 10 && ((b >> 3) & 1) == a2 &&
           (kb == 8 || ((b >> 2) & 1) == a1)) ? 1 : 0;
    page = hit ? ((kb == 8) ? (b >> 1) & 3 : (b >> 1) & 1) : 0;
    dir  = hit ? (b & 1) : 0;
  endtask

  task automatic check_all(input string req, input int m, input int a, input int s);
    for (int c = 0; c < NCFG; c++) begin
      check(req, c, int'(am[c]), m);
      check(req, c, int'(ak[c]), a);
      check(req, c, int'(ds[c]), s);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int hit, page, dir;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int c = 0; c < NCFG; c++) begin
      check("R1", c, int'(am[c]), 0); check("R1", c, int'(ak[c]), 0);
      check("R1", c, int'(pg[c]), 0); check("R1", c, int'(rd[c]), 0);
      check("R1", c, int'(ds[c]), 0); check("R1", c, int'(db[c]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R12: byte before any START is ignored
    cycle(0, 0, 1, 8'hA0);
    check_all("R12", 0, 0, 0);
    cycle(0, 0, 0, 0);

    // Sweep every strap setting and every address byte: R2 R3 R4 R5 R6 R8, then R7 R9 R10
    for (int pins = 0; pins < 8; pins++) begin
      strap_pins = pins[2:0];
      for (int b = 0; b < 256; b++) begin
        cycle(1, 0, 0, 0);
        cycle(0, 0, 1, b);
        for (int c = 0; c < NCFG; c++) begin
          model(CFG_KB[c], CFG_SP[c], b, pins, hit, page, dir);
          check((CFG_SP[c] != 0) ? "R8" : ((CFG_KB[c] == 8) ? "R4" : "R3"), c, int'(am[c]), hit);
          check("R6", c, int'(ak[c]), hit);
          check("R2", c, int'(am[c]) & ((b / 16) != 10 ? 1 : 0), 0);
          check((CFG_KB[c] == 8) ? "R4" : "R3", c, int'(pg[c]), page);
          check("R5", c, int'(rd[c]), dir);
        end
        cycle(0, 0, 1, b ^ 8'h5A);
        for (int c = 0; c < NCFG; c++) begin
          model(CFG_KB[c], CFG_SP[c], b, pins, hit, page, dir);
          check(hit ? "R9" : "R7", c, int'(ds[c]), hit);
          check(hit ? "R9" : "R7", c, int'(ak[c]), 0);
          check("R6", c, int'(am[c]), hit);
          check("R9", c, int'(pg[c]), page);
          check("R9", c, int'(rd[c]), dir);
          if (hit) check("R9", c, int'(db[c]), (b ^ 8'h5A) & 255);
        end
        cycle(0, 1, 0, 0);
        for (int c = 0; c < NCFG; c++) begin
          check("R10", c, int'(am[c]), 0);
          check("R10", c, int'(pg[c]), 0);
          check("R10", c, int'(rd[c]), 0);
        end
      end
    end
    strap_pins = 3'b000;

    // R10: byte together with STOP is discarded
    cycle(1, 0, 0, 0);
    cycle(0, 0, 1, 8'hA3);
    check_all("R6", 1, 1, 0);
    cycle(0, 1, 1, 8'h77);
    check_all("R10", 0, 0, 0);
    cycle(0, 0, 1, 8'hA0);
    check_all("R10", 0, 0, 0);

    // R11: byte together with START is discarded, next byte decoded
    cycle(1, 0, 1, 8'hA0);
    check_all("R11", 0, 0, 0);
    cycle(0, 0, 1, 8'hA1);
    check_all("R11", 1, 1, 0);
    for (int c = 0; c < NCFG; c++) check("R11", c, int'(rd[c]), 1);

    // R11 + R7: repeated START with a foreign type code, then bytes ignored
    cycle(1, 0, 0, 0);
    check_all("R11", 0, 0, 0);
    cycle(0, 0, 1, 8'h50);
    check_all("R7", 0, 0, 0);
    cycle(0, 0, 1, 8'hA0);
    check_all("R7", 0, 0, 0);
    cycle(0, 0, 0, 0);
    check_all("R7", 0, 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule